// File: doc/BRIEF.md
# Four-Word Register File with Separate Read and Write Ports

This block holds four 4-bit words. A write port and a read port work side by side: each has its own 2-bit word select and its own active-low enable. With its enable low, the write port stores its data word into the selected word on the rising clock edge. With its enable low, the read port shows the selected word on its data output. With the read enable high, the output lets go of the bus and goes to high impedance. Other drivers can then share the same wires.

A read and a write may happen in the same cycle, to the same word or to different words. The read path is combinational from the read select and the stored words. A read of the word being written therefore shows the old contents until the clock edge and the new contents after it. A synchronous reset clears every word to zero. It exists so that a test bench can start from a known state.

Top module: `dual_port_regfile4`

## Requirements
- R1: The block holds four independent 4-bit words, and each word keeps its value until it is written again or reset.
- R2: On a rising clock edge with `wr_en_n` = 0, the word whose index is `wr_sel` takes the value of `wr_data`. `wr_sel` is a plain binary index with bit 1 as the high bit, so `wr_sel` = 2'b01 writes word 1.
- R3: On a rising clock edge with `wr_en_n` = 1, no word changes, whatever `wr_sel` and `wr_data` hold.
- R4: While `rd_en_n` = 0, `rd_data` equals the word whose index is `rd_sel`, with no clock delay. `rd_sel` is a plain binary index with bit 1 as the high bit, so `rd_sel` = 2'b10 reads word 2.
- R5: While `rd_en_n` = 1, every bit of `rd_data` is high impedance, so a pull-up on the bus sets the level it shows.
- R6: When a cycle both reads and writes the same word, `rd_data` shows the old value before the clock edge and the new value after it.
- R7: A write changes only the selected word; the other three keep their values.
- R8: On a rising clock edge with `rst` = 1, all four words become 0. Reset overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all words |
| wr_data | input | 4 | Word to be stored |
| wr_sel | input | 2 | Index of the word to write |
| wr_en_n | input | 1 | Write enable, active low |
| rd_sel | input | 2 | Index of the word to read |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 4 | Selected word, or high impedance while reading is disabled |

## Verification
Two latencies matter. A change on the read select or read enable shows on `rd_data` in the same cycle. A write shows on reads only after the next rising edge. The bench drives new inputs at each falling edge and samples `rd_data` a nanosecond later. At that point the reference model still holds the contents from before the coming edge, which is the old-value rule for a same-word read and write. The model is updated only after the rising edge. The bench net carries a pull-up, so a bus that is let go reads as all ones. Every disabled-read cycle is compared against that level while a word of zeros is stored.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_WORDS = 4;
  localparam int unsigned RF_WIDTH = 4;
  localparam int unsigned RF_SEL_W = $clog2(RF_WORDS);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned WORDS = rf_pkg::RF_WORDS,
  localparam int unsigned SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             en_n,
  output logic [WORDS-1:0] strobe
);
  for (genvar i = 0; i < WORDS; i++) begin : g_dec
    assign strobe[i] = !en_n && (sel == SEL_W'(i));
  end

  // R2: at most one word is written per edge
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
  // R3: a disabled port writes nothing
  assert_idle_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (strobe == '0));
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned WORDS = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORDS-1:0]            strobe,
  input  logic [WIDTH-1:0]            din,
  output logic [WORDS-1:0][WIDTH-1:0] words
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)            words[i] <= '0;
      else if (strobe[i]) words[i] <= din;
    end

    // R7, R3: an unstrobed word keeps its value
    assert_keep_word_R7: assert property (@(posedge clk) disable iff (rst)
      !strobe[i] |=> $stable(words[i]));
    // R2: a strobed word takes the data
    assert_take_data_R2: assert property (@(posedge clk) disable iff (rst)
      strobe[i] |=> (words[i] == $past(din)));
    // R8: reset clears the word, even when a write is pending
    assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (words[i] == '0));
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned WORDS = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned SEL_W = $clog2(WORDS)
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [SEL_W-1:0]            sel,
  input  logic                        en_n,
  output logic [WIDTH-1:0]            dout
);
  logic [WIDTH-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (sel == SEL_W'(i)) picked = words[i];
    end
  end

  assign dout = en_n ? 'z : picked;
endmodule

// File: rtl/dual_port_regfile4.sv
module dual_port_regfile4 #(
  parameter int unsigned WORDS = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_en_n,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data
);
  logic [WORDS-1:0]            strobe;
  logic [WORDS-1:0][WIDTH-1:0] words;

  rf_wr_decode #(.WORDS(WORDS)) wr_dec_i (
    .clk(clk), .rst(rst), .sel(wr_sel), .en_n(wr_en_n), .strobe(strobe)
  );

  rf_store #(.WORDS(WORDS), .WIDTH(WIDTH)) store_i (
    .clk(clk), .rst(rst), .strobe(strobe), .din(wr_data), .words(words)
  );

  rf_rd_port #(.WORDS(WORDS), .WIDTH(WIDTH)) rd_port_i (
    .words(words), .sel(rd_sel), .en_n(rd_en_n), .dout(rd_data)
  );

  // R4: an enabled read shows the stored word picked by the select
  assert_read_match_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en_n |-> (rd_data == words[rd_sel]));
endmodule

// File: tb/dual_port_regfile4_tb_top.sv
module dual_port_regfile4_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] wr_data;
  logic [1:0] wr_sel;
  logic       wr_en_n;
  logic [1:0] rd_sel;
  logic       rd_en_n;
  wire  [3:0] rd_bus;

  int checks = 0;
  int fails  = 0;
  int model [4];

  always #4 clk = ~clk;   // 125 MHz

  pullup pu0 (rd_bus[0]);
  pullup pu1 (rd_bus[1]);
  pullup pu2 (rd_bus[2]);
  pullup pu3 (rd_bus[3]);

  dual_port_regfile4 dut_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_sel(wr_sel),
    .wr_en_n(wr_en_n), .rd_sel(rd_sel), .rd_en_n(rd_en_n), .rd_data(rd_bus)
  );

  task automatic compare(input string tag);
    int exp;
    string t;
    exp = rd_en_n ? 15 : model[rd_sel];
    t = tag;
    if (t == "") begin
      if (rd_en_n) t = "R5";
      else if (!wr_en_n && !rst && wr_sel == rd_sel) t = "R6";
      else t = "R4";
    end
    checks++;
    if (int'(rd_bus) != exp) begin
      fails++;
      $display("FAIL %s: rd_data actual %h expected %h (rd_sel=%0d rd_en_n=%b)",
               t, rd_bus, exp[3:0], rd_sel, rd_en_n);
    end
  endtask

  // drive at falling edge, compare shortly after, update model at rising edge
  task automatic step(input logic r, input logic we_n, input logic [1:0] ws,
                      input logic [3:0] wd, input logic re_n,
                      input logic [1:0] rs, input string tag);
    @(negedge clk);
    rst = r; wr_en_n = we_n; wr_sel = ws; wr_data = wd;
    rd_en_n = re_n; rd_sel = rs;
    #1 if (!r) compare(tag);
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 4; i++) model[i] = 0;
    end else if (!we_n) begin
      model[ws] = int'(wd);
    end
  endtask

  initial begin
    rst = 1'b1; wr_en_n = 1'b1; wr_sel = '0; wr_data = '0;
    rd_en_n = 1'b1; rd_sel = '0;
    for (int i = 0; i < 4; i++) model[i] = 0;
    step(1, 1, 0, 0, 1, 0, "R8");
    step(1, 1, 0, 0, 1, 0, "R8");
    // R8: reset state is all zeros
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 2'(i), "R8");
    // R5: disabled read floats to pull-up level although word 0 is zero
    step(0, 1, 0, 0, 1, 0, "R5");
    // R2: select 2'b01 writes word 1, others untouched (R7)
    step(0, 0, 2'b01, 4'hA, 1, 0, "R2");
    step(0, 1, 0, 0, 0, 2'b01, "R2");
    step(0, 1, 0, 0, 0, 2'b00, "R7");
    step(0, 1, 0, 0, 0, 2'b10, "R7");
    // R1: four distinct words held
    for (int i = 0; i < 4; i++) step(0, 0, 2'(i), 4'(i * 5 + 3), 1, 0, "R1");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 2'(i), "R1");
    // R3: disabled write leaves word 2 alone
    step(0, 1, 2'b10, 4'hF, 1, 0, "R3");
    step(0, 1, 0, 0, 0, 2'b10, "R3");
    // R6: same-word read and write: old before edge, new after
    step(0, 0, 2'b10, 4'h9, 0, 2'b10, "R6");
    step(0, 1, 0, 0, 0, 2'b10, "R6");
    // R4: read select 2'b10 picks word 2 while word 3 is written
    step(0, 0, 2'b11, 4'h1, 0, 2'b10, "R4");
    // R8: reset overrides a simultaneous write
    step(1, 0, 2'b00, 4'h7, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 2'(i), "R8");
    // mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] d;
      logic [1:0] a, b;
      logic we, re;
      d = 4'($urandom); a = 2'($urandom); b = 2'($urandom);
      we = 1'($urandom); re = ($urandom % 4) == 0;
      step(0, we, a, d, re, b, "");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule